// File: doc/BRIEF.md
# Memory-Mapped Cache Tag Store Port

This block holds the tag store of a direct-mapped data cache and lets software reach it as a memory-mapped region. Each entry keeps a physical tag, a dirty flag and a valid flag. A bus access whose address carries the array-select code is decoded into an entry index and an associative-mode flag. The write data is decoded into a tag and the two flags. Reads return the entry contents. Plain writes replace an entry outright. Associative writes compare a supplied tag against the stored one, and change the flags only on a valid match. They are mostly used to invalidate a single line by address.

Before a dirty line is overwritten or loses its dirty or valid flag, the block asks an external write-back engine to flush it. It holds the bus response until that engine acknowledges. For associative writes the supplied tag can be passed through an external translation port first. A translation miss makes the operation a silent no-op. A multiple-hit answer raises an exception pulse and aborts the operation. The data array, the bus fabric and the translation hardware itself lie outside the block.

Top module: `tag_store_port`

## Requirements
- R1: After reset every entry reads back as all zeros: tag 0, dirty 0, valid 0.
- R2: An access is to the array only when address bits [31:24] equal 0xF4. Any other access completes with read data 0 and changes no entry.
- R3: A read returns the addressed entry as tag in bits [31:10], zeros in [9:2], dirty in bit 1 and valid in bit 0. The entry index is taken from address bits [13:5]. Address bit 3 (associative flag) has no effect on reads.
- R4: A write with address bit 3 at 0 stores tag (data [31:10]), dirty (data bit 1) and valid (data bit 0) into the entry. Data bits [9:2] are ignored.
- R5: A write with address bit 3 at 0 to an entry whose dirty and valid flags are both 1 issues exactly one write-back request before the new values are stored. The request carries the old tag and the entry index.
- R6: A write with address bit 3 at 1 updates only the dirty and valid flags, and leaves the stored tag as it is. It acts only when the compare tag equals the stored tag and the stored valid flag is 1. Otherwise nothing changes and no write-back is issued.
- R7: An acting associative write on an entry whose dirty flag is 1 issues one write-back request first, if it writes 0 to the dirty flag or to the valid flag.
- R8: With translation enabled, an associative write first translates data [31:10]. The returned physical tag becomes the compare tag. A translation miss changes nothing, raises no exception and issues no write-back.
- R9: A multiple-hit translation answer raises the exception output for one cycle, aborts the write and issues no write-back.
- R10: The bus ready output is a one-cycle pulse and stays low while a write-back is outstanding. A write-back request holds its tag and index steady until acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Access request, held until bus_ready |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Access address (select code, index, associative flag) |
| bus_wdata | input | 32 | Write data (tag, dirty, valid) |
| bus_ready | output | 1 | One-cycle completion pulse |
| bus_rdata | output | 32 | Read data, valid with bus_ready |
| xlat_on | input | 1 | Translate the compare tag of associative writes |
| xlat_req | output | 1 | Translation request, held until xlat_done |
| xlat_vtag | output | 22 | Tag to translate |
| xlat_done | input | 1 | Translation answer valid |
| xlat_ptag | input | 22 | Translated physical tag |
| xlat_miss | input | 1 | Translation found no mapping |
| xlat_multi | input | 1 | Translation found several mappings |
| wb_req | output | 1 | Write-back request, held until wb_ack |
| wb_tag | output | 22 | Tag of the line to flush |
| wb_index | output | INDEX_W | Index of the line to flush |
| wb_ack | input | 1 | Write-back done |
| exc_multi_hit | output | 1 | Multiple-hit exception pulse |

## Verification
On every cycle the assertions check the handshakes. bus_ready is a single pulse and never rises while a write-back is pending. Write-back and translation requests hold until answered, with a steady tag and index. An exception happens only on a multiple-hit answer, and the bus completes right after it with no flush. Only the bench scenarios can show which entry values and how many write-backs result from a given mix of plain, associative, translated and unselected accesses. These include tag mismatches, invalid entries, translation misses and ignored reserved bits, each compared against a reference model of the tag store.

// File: rtl/tsp_pkg.sv
// Shared constants, types and helpers for the tag store port.
// Assumes a 32-bit bus and a tag field at data bits [31:10].
package tsp_pkg;
    localparam int TAG_W = 22;
    localparam int RSVD_W = 32 - TAG_W - 2;
    localparam logic [7:0] ARRAY_SEL = 8'hF4;
    localparam int IDX_LSB = 5;
    localparam int ASSOC_BIT = 3;

    typedef enum logic [2:0] {
        S_IDLE,
        S_EVAL,
        S_XLAT,
        S_CHECK,
        S_WB,
        S_COMMIT,
        S_RESP
    } seq_state_e;

    // Build the read-data image of one entry.
    function automatic logic [31:0] pack_entry(logic [TAG_W-1:0] t, logic u, logic v);
        return {t, {RSVD_W{1'b0}}, u, v};
    endfunction
endpackage

// File: rtl/tsp_field_decode.sv
// Splits a bus access into the fields used by the sequencer.
// Assumes INDEX_W <= 9 so the index fits address bits [13:5].
module tsp_field_decode
    import tsp_pkg::*;
#(
    parameter int INDEX_W = 9
) (
    input  logic [31:0]        addr,
    input  logic [31:0]        wdata,
    output logic               sel,
    output logic [INDEX_W-1:0] index,
    output logic               assoc,
    output logic [TAG_W-1:0]   tag,
    output logic               dirty,
    output logic               valid
);
    logic unused_fields;

    // Field extraction; reserved data bits are dropped here.
    always_comb begin
        sel   = (addr[31:24] == ARRAY_SEL);
        index = addr[IDX_LSB +: INDEX_W];
        assoc = addr[ASSOC_BIT];
        tag   = wdata[31:32-TAG_W];
        dirty = wdata[1];
        valid = wdata[0];
    end

    assign unused_fields = ^{addr[23:0], wdata[31-TAG_W:2]};
endmodule

// File: rtl/tsp_tag_ram.sv
// Flop-based tag store: combinational read, one write port.
// Assumes a single writer; reset clears every tag and flag.
module tsp_tag_ram
    import tsp_pkg::*;
#(
    parameter int INDEX_W = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INDEX_W-1:0] idx,
    output logic [TAG_W-1:0]   rd_tag,
    output logic               rd_dirty,
    output logic               rd_valid,
    input  logic               we,
    input  logic [TAG_W-1:0]   wr_tag,
    input  logic               wr_dirty,
    input  logic               wr_valid
);
    localparam int ENTRIES = 1 << INDEX_W;

    logic [TAG_W-1:0]   tags [ENTRIES];
    logic [ENTRIES-1:0] dirty_q;
    logic [ENTRIES-1:0] valid_q;

    // Entry storage with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                tags[i] <= '0;
            end
            dirty_q <= '0;
            valid_q <= '0;
        end else if (we) begin
            tags[idx]    <= wr_tag;
            dirty_q[idx] <= wr_dirty;
            valid_q[idx] <= wr_valid;
        end
    end

    // Read of the addressed entry.
    always_comb begin
        rd_tag   = tags[idx];
        rd_dirty = dirty_q[idx];
        rd_valid = valid_q[idx];
    end
endmodule

// File: rtl/tsp_sequencer.sv
// Operation sequencer: latches one access and evaluates it against the
// stored entry. It runs translation, compare, write-back and commit as
// needed, then pulses bus_ready.
// Assumes bus_valid is held until bus_ready and dropped right after it.
module tsp_sequencer
    import tsp_pkg::*;
#(
    parameter int INDEX_W = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_valid,
    input  logic               bus_write,
    input  logic               dec_sel,
    input  logic [INDEX_W-1:0] dec_index,
    input  logic               dec_assoc,
    input  logic [TAG_W-1:0]   dec_tag,
    input  logic               dec_dirty,
    input  logic               dec_valid,
    input  logic               xlat_on,
    input  logic [TAG_W-1:0]   st_tag,
    input  logic               st_dirty,
    input  logic               st_valid,
    output logic [INDEX_W-1:0] ent_index,
    output logic               xlat_req,
    output logic [TAG_W-1:0]   xlat_vtag,
    input  logic               xlat_done,
    input  logic [TAG_W-1:0]   xlat_ptag,
    input  logic               xlat_miss,
    input  logic               xlat_multi,
    output logic               wb_req,
    output logic [TAG_W-1:0]   wb_tag,
    output logic [INDEX_W-1:0] wb_index,
    input  logic               wb_ack,
    output logic               we,
    output logic [TAG_W-1:0]   wr_tag,
    output logic               wr_dirty,
    output logic               wr_valid,
    output logic               bus_ready,
    output logic [31:0]        bus_rdata,
    output logic               exc_multi_hit
);
    seq_state_e         state;
    logic               lat_write;
    logic               lat_sel;
    logic               lat_assoc;
    logic [INDEX_W-1:0] lat_index;
    logic [TAG_W-1:0]   lat_tag;
    logic               lat_dirty;
    logic               lat_valid;
    logic [TAG_W-1:0]   cmp_tag;
    logic [31:0]        rdata_q;
    logic               hit;
    logic               clears_dirty;

    // Decisions taken on the stored entry.
    always_comb begin
        hit          = st_valid && (st_tag == cmp_tag);
        clears_dirty = st_dirty && !(lat_dirty && lat_valid);
    end

    // State walk and request latching.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            lat_write <= 1'b0;
            lat_sel   <= 1'b0;
            lat_assoc <= 1'b0;
            lat_index <= '0;
            lat_tag   <= '0;
            lat_dirty <= 1'b0;
            lat_valid <= 1'b0;
            cmp_tag   <= '0;
            rdata_q   <= '0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (bus_valid) begin
                        lat_write <= bus_write;
                        lat_sel   <= dec_sel;
                        lat_assoc <= dec_assoc;
                        lat_index <= dec_index;
                        lat_tag   <= dec_tag;
                        lat_dirty <= dec_dirty;
                        lat_valid <= dec_valid;
                        state     <= S_EVAL;
                    end
                end
                S_EVAL: begin
                    rdata_q <= '0;
                    if (!lat_sel) begin
                        state <= S_RESP;
                    end else if (!lat_write) begin
                        rdata_q <= pack_entry(st_tag, st_dirty, st_valid);
                        state   <= S_RESP;
                    end else if (!lat_assoc) begin
                        state <= (st_dirty && st_valid) ? S_WB : S_COMMIT;
                    end else if (xlat_on) begin
                        state <= S_XLAT;
                    end else begin
                        cmp_tag <= lat_tag;
                        state   <= S_CHECK;
                    end
                end
                S_XLAT: begin
                    if (xlat_done) begin
                        cmp_tag <= xlat_ptag;
                        state   <= (xlat_multi || xlat_miss) ? S_RESP : S_CHECK;
                    end
                end
                S_CHECK: begin
                    if (!hit) begin
                        state <= S_RESP;
                    end else begin
                        state <= clears_dirty ? S_WB : S_COMMIT;
                    end
                end
                S_WB: begin
                    if (wb_ack) begin
                        state <= S_COMMIT;
                    end
                end
                S_COMMIT: state <= S_RESP;
                default:  state <= S_IDLE;
            endcase
        end
    end

    // Output decode from state and latched request.
    always_comb begin
        ent_index     = lat_index;
        xlat_req      = (state == S_XLAT);
        xlat_vtag     = lat_tag;
        wb_req        = (state == S_WB);
        wb_tag        = st_tag;
        wb_index      = lat_index;
        we            = (state == S_COMMIT);
        wr_tag        = lat_assoc ? st_tag : lat_tag;
        wr_dirty      = lat_dirty;
        wr_valid      = lat_valid;
        bus_ready     = (state == S_RESP);
        bus_rdata     = rdata_q;
        exc_multi_hit = (state == S_XLAT) && xlat_done && xlat_multi;
    end
endmodule

// File: rtl/tag_store_port.sv
// Top of the memory-mapped tag store port: field decode, tag storage and
// the operation sequencer.
// Assumes INDEX_W <= 9; translation and write-back engines are external.
module tag_store_port
    import tsp_pkg::*;
#(
    parameter int INDEX_W = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_valid,
    input  logic               bus_write,
    input  logic [31:0]        bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic               bus_ready,
    output logic [31:0]        bus_rdata,
    input  logic               xlat_on,
    output logic               xlat_req,
    output logic [21:0]        xlat_vtag,
    input  logic               xlat_done,
    input  logic [21:0]        xlat_ptag,
    input  logic               xlat_miss,
    input  logic               xlat_multi,
    output logic               wb_req,
    output logic [21:0]        wb_tag,
    output logic [INDEX_W-1:0] wb_index,
    input  logic               wb_ack,
    output logic               exc_multi_hit
);
    logic               dec_sel;
    logic [INDEX_W-1:0] dec_index;
    logic               dec_assoc;
    logic [TAG_W-1:0]   dec_tag;
    logic               dec_dirty;
    logic               dec_valid;
    logic [INDEX_W-1:0] ent_index;
    logic [TAG_W-1:0]   st_tag;
    logic               st_dirty;
    logic               st_valid;
    logic               we;
    logic [TAG_W-1:0]   wr_tag;
    logic               wr_dirty;
    logic               wr_valid;

    tsp_field_decode #(.INDEX_W(INDEX_W)) u_dec (
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .sel   (dec_sel),
        .index (dec_index),
        .assoc (dec_assoc),
        .tag   (dec_tag),
        .dirty (dec_dirty),
        .valid (dec_valid)
    );

    tsp_tag_ram #(.INDEX_W(INDEX_W)) u_ram (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx      (ent_index),
        .rd_tag   (st_tag),
        .rd_dirty (st_dirty),
        .rd_valid (st_valid),
        .we       (we),
        .wr_tag   (wr_tag),
        .wr_dirty (wr_dirty),
        .wr_valid (wr_valid)
    );

    tsp_sequencer #(.INDEX_W(INDEX_W)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_valid     (bus_valid),
        .bus_write     (bus_write),
        .dec_sel       (dec_sel),
        .dec_index     (dec_index),
        .dec_assoc     (dec_assoc),
        .dec_tag       (dec_tag),
        .dec_dirty     (dec_dirty),
        .dec_valid     (dec_valid),
        .xlat_on       (xlat_on),
        .st_tag        (st_tag),
        .st_dirty      (st_dirty),
        .st_valid      (st_valid),
        .ent_index     (ent_index),
        .xlat_req      (xlat_req),
        .xlat_vtag     (xlat_vtag),
        .xlat_done     (xlat_done),
        .xlat_ptag     (xlat_ptag),
        .xlat_miss     (xlat_miss),
        .xlat_multi    (xlat_multi),
        .wb_req        (wb_req),
        .wb_tag        (wb_tag),
        .wb_index      (wb_index),
        .wb_ack        (wb_ack),
        .we            (we),
        .wr_tag        (wr_tag),
        .wr_dirty      (wr_dirty),
        .wr_valid      (wr_valid),
        .bus_ready     (bus_ready),
        .bus_rdata     (bus_rdata),
        .exc_multi_hit (exc_multi_hit)
    );
endmodule

// File: rtl/tsp_checker.sv
// Handshake and exception properties of the tag store port, bound to the
// top module. Observes ports only.
module tsp_checker #(
    parameter int INDEX_W = 9
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_ready,
    input logic               xlat_req,
    input logic               xlat_done,
    input logic               xlat_multi,
    input logic               wb_req,
    input logic [21:0]        wb_tag,
    input logic [INDEX_W-1:0] wb_index,
    input logic               wb_ack,
    input logic               exc_multi_hit
);
    a_r10_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |=> !bus_ready);

    a_r10_wb_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req && !wb_ack) |=> (wb_req && $stable(wb_tag) && $stable(wb_index)));

    a_r5_no_ready_while_flushing: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req |-> !bus_ready);

    a_r8_xlat_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (xlat_req && !xlat_done) |=> xlat_req);

    a_r9_exc_on_multi: assert property (@(posedge clk) disable iff (!rst_n)
        exc_multi_hit |-> (xlat_req && xlat_done && xlat_multi));

    a_r9_abort_completes: assert property (@(posedge clk) disable iff (!rst_n)
        exc_multi_hit |=> (bus_ready && !wb_req));
endmodule

bind tag_store_port tsp_checker #(.INDEX_W(INDEX_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_ready     (bus_ready),
    .xlat_req      (xlat_req),
    .xlat_done     (xlat_done),
    .xlat_multi    (xlat_multi),
    .wb_req        (wb_req),
    .wb_tag        (wb_tag),
    .wb_index      (wb_index),
    .wb_ack        (wb_ack),
    .exc_multi_hit (exc_multi_hit)
);

// File: tb/tb_tag_store_port.sv
// Sweeps a 16-entry tag store through directed and pseudo-random access
// mixes, comparing against a reference model kept in the bench.
module tb_tag_store_port;
    localparam int IW = 4;
    localparam int N  = 1 << IW;
    localparam logic [21:0] KEY = 22'h2A5A5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_valid = 1'b0;
    logic          bus_write = 1'b0;
    logic [31:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic          bus_ready;
    logic [31:0]   bus_rdata;
    logic          xlat_on = 1'b0;
    logic          xlat_req;
    logic [21:0]   xlat_vtag;
    logic          xlat_done = 1'b0;
    logic [21:0]   xlat_ptag = '0;
    logic          xlat_miss = 1'b0;
    logic          xlat_multi = 1'b0;
    logic          wb_req;
    logic [21:0]   wb_tag;
    logic [IW-1:0] wb_index;
    logic          wb_ack = 1'b0;
    logic          exc_multi_hit;

    int checks = 0;
    int errors = 0;
    int xl_mode = 0;      // 0 hit, 1 miss, 2 multiple hit
    int wb_cnt = 0;
    int exc_cnt = 0;
    int exp_wb = 0;
    int exp_exc = 0;
    int wb_dly = 0;
    logic [21:0]   last_wb_tag = '0;
    logic [IW-1:0] last_wb_idx = '0;
    logic [31:0]   rd_last;

    logic [21:0] m_tag [N];
    bit          m_u [N];
    bit          m_v [N];

    always #4 clk = ~clk;

    tag_store_port #(.INDEX_W(IW)) dut (.*);

    // Event counters sampled at the active edge.
    always @(posedge clk) begin
        if (wb_req && wb_ack) begin
            wb_cnt++;
            last_wb_tag = wb_tag;
            last_wb_idx = wb_index;
        end
        if (exc_multi_hit) exc_cnt++;
    end

    // Translation and write-back responders, driven away from the edge.
    always @(negedge clk) begin
        if (xlat_done) begin
            xlat_done = 1'b0;
        end else if (xlat_req) begin
            xlat_done  = 1'b1;
            xlat_ptag  = xlat_vtag ^ KEY;
            xlat_miss  = (xl_mode == 1);
            xlat_multi = (xl_mode == 2);
        end
        if (wb_ack) begin
            wb_ack = 1'b0;
        end else if (wb_req) begin
            wb_dly++;
            if (wb_dly >= 3) begin
                wb_ack = 1'b1;
                wb_dly = 0;
            end
        end
    end

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_addr(int idx, bit assoc);
        return 32'hF400_0000 | (32'(idx) << 5) | (32'(assoc) << 3);
    endfunction

    function automatic logic [31:0] mk_data(logic [21:0] t, bit u, bit v, bit rsvd);
        return {t, rsvd ? 8'hFF : 8'h00, u, v};
    endfunction

    // Reference model of one access.
    task automatic model(bit w, logic [31:0] a, logic [31:0] d, output logic [31:0] er);
        int idx = int'(a[8:5]);
        logic [21:0] t = d[31:10];
        er = '0;
        if (a[31:24] == 8'hF4) begin
            if (!w) begin
                er = {m_tag[idx], 8'h00, m_u[idx], m_v[idx]};
            end else if (!a[3]) begin
                if (m_u[idx] && m_v[idx]) exp_wb++;
                m_tag[idx] = t;
                m_u[idx] = d[1];
                m_v[idx] = d[0];
            end else begin
                bit go = 1'b1;
                if (xlat_on) begin
                    if (xl_mode == 2) begin
                        exp_exc++;
                        go = 1'b0;
                    end else if (xl_mode == 1) begin
                        go = 1'b0;
                    end else begin
                        t = t ^ KEY;
                    end
                end
                if (go && m_v[idx] && m_tag[idx] == t) begin
                    if (m_u[idx] && !(d[1] && d[0])) exp_wb++;
                    m_u[idx] = d[1];
                    m_v[idx] = d[0];
                end
            end
        end
    endtask

    // One bus access, checked against the model.
    task automatic run(bit w, logic [31:0] a, logic [31:0] d, string req);
        logic [31:0] er;
        model(w, a, d, er);
        @(negedge clk);
        bus_valid = 1'b1;
        bus_write = w;
        bus_addr  = a;
        bus_wdata = d;
        do @(negedge clk); while (!bus_ready);
        rd_last = bus_rdata;
        bus_valid = 1'b0;
        if (!w) check(rd_last == er, req, rd_last, er);
        check(wb_cnt == exp_wb, {req, " wb count"}, 32'(wb_cnt), 32'(exp_wb));
        check(exc_cnt == exp_exc, {req, " exc count"}, 32'(exc_cnt), 32'(exp_exc));
    endtask

    task automatic read_all(string req);
        for (int i = 0; i < N; i++) run(1'b0, mk_addr(i, i[0]), '0, req);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] lfsr = 32'hACE1_1234;
        for (int i = 0; i < N; i++) begin
            m_tag[i] = '0;
            m_u[i] = 1'b0;
            m_v[i] = 1'b0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: idle outputs and cleared contents after reset
        check(!bus_ready && !wb_req && !xlat_req && !exc_multi_hit, "R1 idle outputs",
              {28'h0, bus_ready, wb_req, xlat_req, exc_multi_hit}, 32'h0);
        read_all("R1 reset contents");

        // R4, R3: plain writes with reserved bits set, then read back (A set on odd)
        for (int i = 0; i < N; i++)
            run(1'b1, mk_addr(i, 1'b0), mk_data(22'(i * 32'h1357 + 5), i[0], i[1], 1'b1), "R4 plain write");
        read_all("R3 R4 readback");

        // R5: overwrite; dirty+valid entries flush with old tag and index
        for (int i = 0; i < N; i++)
            run(1'b1, mk_addr(i, 1'b0), mk_data(22'(i * 32'h0F0F1 + 3), 1'b1, 1'b1, 1'b0), "R5 overwrite");
        run(1'b1, mk_addr(7, 1'b0), mk_data(22'h12345, 1'b0, 1'b1, 1'b0), "R5 flush");
        check(last_wb_tag == 22'(7 * 32'h0F0F1 + 3), "R5 flushed tag", 32'(last_wb_tag), 32'(22'(7 * 32'h0F0F1 + 3)));
        check(last_wb_idx == 4'd7, "R5 flushed index", 32'(last_wb_idx), 32'd7);
        read_all("R5 readback");

        // R6: associative mismatch, match, invalid-entry match
        run(1'b1, mk_addr(3, 1'b1), mk_data(22'h3FFFF, 1'b0, 1'b0, 1'b0), "R6 mismatch");
        run(1'b1, mk_addr(7, 1'b1), mk_data(22'h12345, 1'b1, 1'b1, 1'b0), "R6 match sets dirty");
        run(1'b1, mk_addr(2, 1'b0), mk_data(22'h00AAA, 1'b0, 1'b0, 1'b0), "R6 make invalid");
        run(1'b1, mk_addr(2, 1'b1), mk_data(22'h00AAA, 1'b1, 1'b1, 1'b0), "R6 invalid no-op");
        // R7: associative clear of a dirty line flushes first
        run(1'b1, mk_addr(7, 1'b1), mk_data(22'h12345, 1'b1, 1'b0, 1'b0), "R7 invalidate dirty");
        check(last_wb_idx == 4'd7, "R7 flushed index", 32'(last_wb_idx), 32'd7);
        read_all("R6 R7 readback");

        // R8, R9: translated associative writes
        xlat_on = 1'b1;
        xl_mode = 1;
        run(1'b1, mk_addr(5, 1'b1), mk_data(m_tag[5] ^ KEY, 1'b0, 1'b0, 1'b0), "R8 miss no-op");
        xl_mode = 2;
        run(1'b1, mk_addr(5, 1'b1), mk_data(m_tag[5] ^ KEY, 1'b0, 1'b0, 1'b0), "R9 multi abort");
        xl_mode = 0;
        run(1'b1, mk_addr(5, 1'b1), mk_data(m_tag[5], 1'b0, 1'b0, 1'b0), "R8 untranslated tag misses");
        run(1'b1, mk_addr(5, 1'b1), mk_data(m_tag[5] ^ KEY, 1'b0, 1'b0, 1'b0), "R8 translated hit");
        xlat_on = 1'b0;
        read_all("R8 R9 readback");

        // R2: accesses outside the array
        run(1'b1, 32'hF500_0000 | (32'd4 << 5), mk_data(22'h1, 1'b1, 1'b1, 1'b0), "R2 unselected write");
        run(1'b0, 32'h7400_0000 | (32'd4 << 5), '0, "R2 unselected read");
        run(1'b0, mk_addr(4, 1'b0), '0, "R2 target unchanged");

        // R3..R10: pseudo-random mix over a small tag set
        for (int k = 0; k < 400; k++) begin
            int op;
            int idx;
            logic [21:0] t;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            op  = int'(lfsr[2:0]);
            idx = int'(lfsr[6:3]);
            t   = 22'h100 + 22'(lfsr[8:7]);
            xl_mode = int'(lfsr[10:9]) % 3;
            xlat_on = lfsr[11];
            if (lfsr[14:12] == 3'd0) t = t ^ KEY;
            if (op < 2)
                run(1'b0, mk_addr(idx, lfsr[15]), '0, "R3 random read");
            else if (op < 4)
                run(1'b1, mk_addr(idx, 1'b0), mk_data(t, lfsr[16], lfsr[17], lfsr[18]), "R4 R5 random plain");
            else
                run(1'b1, mk_addr(idx, 1'b1), mk_data(t, lfsr[16], lfsr[17], 1'b0), "R6 R7 R8 R9 random assoc");
        end
        xlat_on = 1'b0;
        read_all("R10 final contents");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule